// File: doc/BRIEF.md
# Platform Reset and Power-Good Sequencer

This block drives the active-low platform reset for the devices on a board. It holds the reset low until both the core power-good and the system power-good are high and a programmable rail-valid delay has passed. It also keeps the reset low while the system is in a sleep state and while a cold, warm or global reset is in progress. The core power-good may change at any time relative to the block clock. Release of the reset waits for it to pass through a two-flop synchronizer. Loss of core power-good pulls the reset low at once, without waiting for a clock edge.

A reset button input is synchronized and debounced. Each accepted press produces one internal reset pulse of a single clock cycle, and the platform reset is pulled low for a warm-reset cycle. A free-running `tick` input, one cycle wide and nominally once per millisecond, paces both the debounce counter and the rail-valid counter. With the defaults, the debounce needs 16 ticks and the rail delay needs 100 ticks.

The sequencer is a six-state machine:
- `ST_OFF`: power not good.
- `ST_RAIL_WAIT`: counting the rail delay.
- `ST_RUN`: reset released.
- `ST_SLEEP`: sleep state.
- `ST_WARM_HOLD`: warm reset or button reset.
- `ST_COLD_HOLD`: cold or global reset.

Its transitions are:
- Power loss: any state goes to `ST_OFF` when the synchronized core power-good or the system power-good is low. This has the highest priority.
- Power good: `ST_OFF` goes to `ST_RAIL_WAIT`.
- Rail done: `ST_RAIL_WAIT` goes to `ST_RUN` after the programmed number of ticks.
- Cold entry: any powered state goes to `ST_COLD_HOLD` on a cold or global request.
- Cold exit: `ST_COLD_HOLD` goes to `ST_RAIL_WAIT` when the request is withdrawn.
- Warm entry: `ST_RUN`, `ST_SLEEP` or a finished `ST_RAIL_WAIT` goes to `ST_WARM_HOLD` on a warm request or a button pulse.
- Warm exit: `ST_WARM_HOLD` goes to `ST_RUN`.
- Sleep entry: `ST_RUN`, `ST_WARM_HOLD` or a finished `ST_RAIL_WAIT` goes to `ST_SLEEP`.
- Sleep exit: `ST_SLEEP` goes to `ST_RUN`.

Among the requests, cold or global has priority over warm or button, and warm or button has priority over sleep.

Top module: `plat_rst_seq`

## Requirements
- R1: When `core_pg_async` is low, `plat_rst_n` is low immediately, without waiting for a clock edge.
- R2: While `sleep_state` is high, `plat_rst_n` is low from the first clock edge that samples it high. When sleep ends with power good, the reset is released at the first edge that samples `sleep_state` low.
- R3: `plat_rst_n` is released only when `sys_pg` and `core_pg_async` are both high. A low `sys_pg` pulls the reset low at the next clock edge.
- R4: After both power-goods are high, with core power-good passed through two synchronizer flops, `plat_rst_n` stays low until `RAIL_TICKS` ticks have been counted. A drop of either power-good restarts the count from zero.
- R5: A cold or global request pulls `plat_rst_n` low at the next edge and holds it low while the request stays high. When the request is withdrawn, the full `RAIL_TICKS` delay runs again before release.
- R6: A warm request pulls `plat_rst_n` low at the next edge and holds it low while the request stays high. The reset is released at the first edge that samples the request low, with no rail delay.
- R7: A change of `rst_btn_n` is accepted only after the new level has been stable for `DEB_TICKS` ticks. Bounces shorter than that produce no pulse and leave `plat_rst_n` high.
- R8: Each accepted press (a high-to-low change of `rst_btn_n`) produces exactly one `btn_rst_pulse` of one clock cycle. Holding the button or releasing it produces no further pulse.
- R9: A `btn_rst_pulse` is followed at the next edge by `plat_rst_n` low for a warm-reset cycle.
- R10: While `rst_n` is low, `plat_rst_n` and `btn_rst_pulse` are low, whatever the power-good inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low block reset, asynchronous |
| tick | input | 1 | One-cycle timebase strobe for the timers |
| core_pg_async | input | 1 | Core power-good, asynchronous to clk |
| sys_pg | input | 1 | System power-good, synchronous to clk |
| rst_btn_n | input | 1 | Reset button, active low, raw and bouncing |
| sleep_state | input | 1 | High while the system is in a sleep state |
| cold_req | input | 1 | Cold reset in progress |
| warm_req | input | 1 | Warm reset in progress |
| global_req | input | 1 | Global reset in progress |
| plat_rst_n | output | 1 | Active-low platform reset |
| btn_rst_pulse | output | 1 | One-cycle internal reset pulse per accepted button press |

## Verification
The bench builds the block with `RAIL_TICKS` = 6 and `DEB_TICKS` = 3, and drives a tick every fourth clock. These values make full power-up, restart and cold-reset windows only a few dozen cycles long, so many of them fit in one run. Bounces can be made both just shorter and just longer than the debounce window. At these sizes the rail-delay restart on a power-good drop and the one-pulse-per-press rule can be measured exactly within their tick windows. Random sequences of sleep, warm and global events with random hold lengths check the priorities and release timing from the running state.

// File: rtl/plat_rst_seq_pkg.sv
package plat_rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_RAIL_WAIT = 3'd1,
        ST_RUN       = 3'd2,
        ST_SLEEP     = 3'd3,
        ST_WARM_HOLD = 3'd4,
        ST_COLD_HOLD = 3'd5
    } seq_state_t;

endpackage

// File: rtl/prs_sync.sv
module prs_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/prs_debounce.sv
module prs_debounce #(
    parameter int DEB_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic btn_n_sync,
    output logic press_pulse
);
    localparam int CW = $clog2(DEB_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

    logic          stable_n;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stable_n    <= 1'b1;
            cnt         <= '0;
            press_pulse <= 1'b0;
        end else begin
            press_pulse <= 1'b0;
            if (btn_n_sync == stable_n) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == LAST) begin
                    stable_n    <= btn_n_sync;
                    cnt         <= '0;
                    press_pulse <= ~btn_n_sync;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/prs_rail_timer.sv
module prs_rail_timer #(
    parameter int RAIL_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(RAIL_TICKS + 1);
    localparam logic [CW-1:0] FULL = CW'(RAIL_TICKS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (tick && cnt != FULL) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == FULL);
endmodule

// File: rtl/plat_rst_seq.sv
module plat_rst_seq
    import plat_rst_seq_pkg::*;
#(
    parameter int RAIL_TICKS  = 100,
    parameter int DEB_TICKS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic core_pg_async,
    input  logic sys_pg,
    input  logic rst_btn_n,
    input  logic sleep_state,
    input  logic cold_req,
    input  logic warm_req,
    input  logic global_req,
    output logic plat_rst_n,
    output logic btn_rst_pulse
);
    seq_state_t state, nxt;

    logic core_arst_n;
    logic core_pg_sync;
    logic btn_n_sync;
    logic rail_done;
    logic pg_ok;
    logic cold_any;
    logic warm_any;
    logic release_q;

    // Loss of core power-good clears the synchronizer at once
    assign core_arst_n = rst_n & core_pg_async;

    prs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_core_sync (
        .clk    (clk),
        .arst_n (core_arst_n),
        .d      (1'b1),
        .q      (core_pg_sync)
    );

    prs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_btn_sync (
        .clk    (clk),
        .arst_n (rst_n),
        .d      (rst_btn_n),
        .q      (btn_n_sync)
    );

    prs_debounce #(.DEB_TICKS(DEB_TICKS)) u_debounce (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .btn_n_sync  (btn_n_sync),
        .press_pulse (btn_rst_pulse)
    );

    prs_rail_timer #(.RAIL_TICKS(RAIL_TICKS)) u_rail (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_RAIL_WAIT),
        .tick  (tick),
        .done  (rail_done)
    );

    assign pg_ok    = core_pg_sync & sys_pg;
    assign cold_any = cold_req | global_req;
    assign warm_any = warm_req | btn_rst_pulse;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (!pg_ok) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: begin
                    nxt = cold_any ? ST_COLD_HOLD : ST_RAIL_WAIT;
                end
                ST_RAIL_WAIT: begin
                    if (cold_any)        nxt = ST_COLD_HOLD;
                    else if (!rail_done) nxt = ST_RAIL_WAIT;
                    else if (warm_any)   nxt = ST_WARM_HOLD;
                    else if (sleep_state) nxt = ST_SLEEP;
                    else                 nxt = ST_RUN;
                end
                ST_RUN: begin
                    if (cold_any)         nxt = ST_COLD_HOLD;
                    else if (warm_any)    nxt = ST_WARM_HOLD;
                    else if (sleep_state) nxt = ST_SLEEP;
                    else                  nxt = ST_RUN;
                end
                ST_SLEEP: begin
                    if (cold_any)         nxt = ST_COLD_HOLD;
                    else if (warm_any)    nxt = ST_WARM_HOLD;
                    else if (sleep_state) nxt = ST_SLEEP;
                    else                  nxt = ST_RUN;
                end
                ST_WARM_HOLD: begin
                    if (cold_any)         nxt = ST_COLD_HOLD;
                    else if (warm_any)    nxt = ST_WARM_HOLD;
                    else if (sleep_state) nxt = ST_SLEEP;
                    else                  nxt = ST_RUN;
                end
                ST_COLD_HOLD: begin
                    nxt = cold_any ? ST_COLD_HOLD : ST_RAIL_WAIT;
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    // Output register: release only in the running state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            release_q <= 1'b0;
        end else begin
            release_q <= (nxt == ST_RUN);
        end
    end

    // Asynchronous assertion path on core power-good loss
    assign plat_rst_n = release_q & core_pg_async;

endmodule

// File: rtl/plat_rst_seq_chk.sv
module plat_rst_seq_chk #(
    parameter int RAIL_TICKS = 100
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic core_pg_async,
    input logic sys_pg,
    input logic sleep_state,
    input logic cold_req,
    input logic warm_req,
    input logic global_req,
    input logic plat_rst_n,
    input logic btn_rst_pulse
);
    localparam int CW = $clog2(RAIL_TICKS + 1);
    localparam logic [CW-1:0] FULL = CW'(RAIL_TICKS);

    logic [CW-1:0] good_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_ticks <= '0;
        end else if (!(core_pg_async && sys_pg) || cold_req || global_req) begin
            good_ticks <= '0;
        end else if (tick && good_ticks != FULL) begin
            good_ticks <= good_ticks + 1'b1;
        end
    end

    AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_state |=> !plat_rst_n); // R2

    AST_SYSPG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_pg |=> !plat_rst_n); // R3

    AST_RELEASE_BOTH_PG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(plat_rst_n) |-> ($past(sys_pg) && core_pg_async)); // R3

    AST_RAIL_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(plat_rst_n) |-> (good_ticks == FULL)); // R4

    AST_COLD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cold_req || global_req) |=> !plat_rst_n); // R5

    AST_WARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        warm_req |=> !plat_rst_n); // R6

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        btn_rst_pulse |=> !btn_rst_pulse); // R8

    AST_PULSE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        btn_rst_pulse |=> !plat_rst_n); // R9

endmodule

bind plat_rst_seq plat_rst_seq_chk #(.RAIL_TICKS(RAIL_TICKS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .core_pg_async (core_pg_async),
    .sys_pg        (sys_pg),
    .sleep_state   (sleep_state),
    .cold_req      (cold_req),
    .warm_req      (warm_req),
    .global_req    (global_req),
    .plat_rst_n    (plat_rst_n),
    .btn_rst_pulse (btn_rst_pulse)
);

// File: tb/plat_rst_seq_bench.sv
`timescale 1ns/1ps
module plat_rst_seq_bench;
    localparam int RAIL     = 6;
    localparam int DEB      = 3;
    localparam int TDIV     = 4;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic core_pg_async = 1'b0;
    logic sys_pg = 1'b0;
    logic rst_btn_n = 1'b1;
    logic sleep_state = 1'b0;
    logic cold_req = 1'b0;
    logic warm_req = 1'b0;
    logic global_req = 1'b0;
    logic plat_rst_n;
    logic btn_rst_pulse;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int tdiv_cnt = 0;
    bit mon_en = 1'b0;
    int pulse_seen = 0;
    int low_seen = 0;

    plat_rst_seq #(.RAIL_TICKS(RAIL), .DEB_TICKS(DEB)) u_plat_rst_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .core_pg_async (core_pg_async),
        .sys_pg        (sys_pg),
        .rst_btn_n     (rst_btn_n),
        .sleep_state   (sleep_state),
        .cold_req      (cold_req),
        .warm_req      (warm_req),
        .global_req    (global_req),
        .plat_rst_n    (plat_rst_n),
        .btn_rst_pulse (btn_rst_pulse)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
        tick     <= (tdiv_cnt == TDIV - 1);
        if (mon_en) begin
            if (btn_rst_pulse) pulse_seen <= pulse_seen + 1;
            if (!plat_rst_n)   low_seen   <= low_seen + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_LIMIT) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Release windows derived from the rail-delay requirement
    function automatic int rel_min();
        return (RAIL - 1) * TDIV;
    endfunction

    function automatic int rel_max();
        return RAIL * TDIV + 8;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure_release(input string req);
        int c = 0;
        while (plat_rst_n !== 1'b1 && c < rel_max() + 20) begin
            step(1);
            c++;
        end
        chk(c >= rel_min() && c <= rel_max(), req, c, rel_max());
    endtask

    // op 0 sleep (R2), 1 warm (R6), 2 global (R5), 3 cold (R5)
    task automatic run_event(input int op, input int hold);
        @(negedge clk);
        case (op)
            0: sleep_state = 1'b1;
            1: warm_req    = 1'b1;
            2: global_req  = 1'b1;
            default: cold_req = 1'b1;
        endcase
        for (int i = 0; i < hold; i++) begin
            step(1);
            if (op == 0) chk(plat_rst_n == 1'b0, "R2 sleep hold", plat_rst_n, 0);
            else if (op == 1) chk(plat_rst_n == 1'b0, "R6 warm hold", plat_rst_n, 0);
            else chk(plat_rst_n == 1'b0, "R5 cold/global hold", plat_rst_n, 0);
        end
        sleep_state = 1'b0;
        warm_req    = 1'b0;
        global_req  = 1'b0;
        cold_req    = 1'b0;
        if (op < 2) begin
            step(1);
            if (op == 0) chk(plat_rst_n == 1'b1, "R2 sleep exit release", plat_rst_n, 1);
            else chk(plat_rst_n == 1'b1, "R6 warm exit release", plat_rst_n, 1);
        end else begin
            measure_release("R5 rail delay after cold/global");
        end
    endtask

    initial begin
        void'($urandom(32'd2024));

        // R10: block reset holds outputs low even with power good
        step(2);
        chk(plat_rst_n == 1'b0, "R10 reset plat_rst_n", plat_rst_n, 0);
        chk(btn_rst_pulse == 1'b0, "R10 reset pulse", btn_rst_pulse, 0);
        core_pg_async = 1'b1;
        sys_pg        = 1'b1;
        step(5);
        chk(plat_rst_n == 1'b0, "R10 reset with pg high", plat_rst_n, 0);

        // R4: power-up release after rail delay
        rst_n = 1'b1;
        measure_release("R4 power-up rail delay");

        // R1: asynchronous assertion between clock edges
        @(negedge clk);
        core_pg_async = 1'b0;
        #2;
        chk(plat_rst_n == 1'b0, "R1 immediate assert", plat_rst_n, 0);
        step(3);
        core_pg_async = 1'b1;
        measure_release("R4 release after core pg return");

        // R3/R4: sys_pg drop, then restart of the count mid-wait
        sys_pg = 1'b0;
        step(1);
        chk(plat_rst_n == 1'b0, "R3 sys_pg drop asserts", plat_rst_n, 0);
        sys_pg = 1'b1;
        step(RAIL * TDIV / 2);
        chk(plat_rst_n == 1'b0, "R4 still waiting", plat_rst_n, 0);
        sys_pg = 1'b0;
        step(1);
        sys_pg = 1'b1;
        measure_release("R4 count restarts after drop");

        // R3: core good but system not good never releases
        sys_pg = 1'b0;
        step(1);
        mon_en = 1'b1; low_seen = 0;
        step(RAIL * TDIV * 3);
        mon_en = 1'b0;
        step(1);
        chk(low_seen == RAIL * TDIV * 3, "R3 no release without sys_pg", low_seen, RAIL * TDIV * 3);
        sys_pg = 1'b1;
        measure_release("R3 release once both pg high");

        // Directed events
        run_event(0, 5);
        run_event(1, 3);
        run_event(3, 4);
        run_event(2, 1);

        // R7: short bounces are ignored
        step(2);
        mon_en = 1'b1; pulse_seen = 0; low_seen = 0;
        for (int i = 0; i < 10; i++) begin
            rst_btn_n = 1'b0;
            step(1 + int'($urandom % ((DEB - 1) * TDIV)));
            rst_btn_n = 1'b1;
            step(1 + int'($urandom % (2 * TDIV)));
        end
        step(DEB * TDIV + 4);
        mon_en = 1'b0;
        step(1);
        chk(pulse_seen == 0, "R7 bounce gives no pulse", pulse_seen, 0);
        chk(low_seen == 0, "R7 bounce keeps reset high", low_seen, 0);

        // R8/R9: a real press
        mon_en = 1'b1; pulse_seen = 0; low_seen = 0;
        rst_btn_n = 1'b0;
        step((DEB + 2) * TDIV + 4);
        chk(pulse_seen == 1, "R8 one pulse per press", pulse_seen, 1);
        chk(low_seen >= 1, "R9 press resets platform", low_seen, 1);
        step((DEB + 2) * TDIV * 4);
        chk(pulse_seen == 1, "R8 no pulse while held", pulse_seen, 1);
        rst_btn_n = 1'b1;
        step((DEB + 2) * TDIV + 4);
        mon_en = 1'b0;
        step(1);
        chk(pulse_seen == 1, "R8 no pulse on release", pulse_seen, 1);
        chk(plat_rst_n == 1'b1, "R9 released after press", plat_rst_n, 1);

        // Random mix of sleep, warm and global events
        for (int k = 0; k < 24; k++) begin
            run_event(int'($urandom % 3), 1 + int'($urandom % 12));
            step(int'($urandom % 4));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule